// File: doc/BRIEF.md
# Two-Player Rope-Pull Light Game

This block is a complete two-player game built around a row of nine indicator lights. At any moment during play exactly one light is lit. Each player has a raw, asynchronous, active-low push button. Player one's presses step the lit spot one place toward the right end of the row, and player two's presses step it one place toward the left end. A player who pushes the spot past their own end of the row wins. A single seven-segment digit then shows the winner's number.

Each button first passes through a two-flop synchronizer. A press detector then turns every press into a pulse that lasts exactly one clock cycle. The playfield is a chain of identical one-bit cells, one per light, and each cell decides its next value from its two neighbours and the two pulses. A small victory unit watches the two end cells and latches the result. Everything runs on one system clock.

Light numbering: `lights_o[0]` is the rightmost light (position 1) and `lights_o[8]` is the leftmost (position 9). The digit output is `seg_o = {g,f,e,d,c,b,a}`, and a segment is on when its bit is 0.

Top module: `rope_game_top`

## Requirements
- R1: While reset is asserted and directly after it, only `lights_o[4]` is lit (9'b000010000) and `seg_o` is blank (7'b1111111).
- R2: A press by player one moves the lit bit from index i to i-1. A press by player two moves it from i to i+1.
- R3: Each raw button passes through two flip-flops before any other logic uses it. A raw level driven low before clock edge k changes `lights_o` right after edge k+2 and not before.
- R4: One press moves the light exactly one step, however many cycles the button is held. The move happens on the transition from released to pressed.
- R5: If both players' press pulses fall in the same cycle, the lights do not move and no win is declared, even when the lit spot is at an end.
- R6: A press by player one alone while `lights_o[0]` is lit wins for player one. All lights go dark and `seg_o` shows 1 (7'b1111001).
- R7: A press by player two alone while `lights_o[8]` is lit wins for player two. All lights go dark and `seg_o` shows 2 (7'b0100100).
- R8: After a win, further presses are ignored. The lights stay dark and the digit stays unchanged until reset.
- R9: Until a win, exactly one light is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_one_ni | input | 1 | Raw button of player one (moves right), active low |
| btn_two_ni | input | 1 | Raw button of player two (moves left), active low |
| lights_o | output | 9 | Playfield lights; bit 0 is the rightmost |
| seg_o | output | 7 | Winner digit {g,f,e,d,c,b,a}, active low |

## Verification
Two functions can land in the same cycle: the press pulses of both players, and a winning push at an end cell together with the opposing player's press. The bench drives both raw buttons low on the same falling clock edge. Both pulses therefore appear in the same cycle, once with the spot in the middle of the row and once with it on the leftmost cell. A cycle-accurate behavioural model predicts no move and no win in both cases. The lights and the digit are compared against that model on every cycle.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_ONE  = 2'd1,
    WIN_TWO  = 2'd2
  } win_e;

  // {g,f,e,d,c,b,a}, active low
  localparam logic [6:0] SEG_BLANK = 7'b1111111;
  localparam logic [6:0] SEG_ONE   = 7'b1111001;
  localparam logic [6:0] SEG_TWO   = 7'b0100100;

  function automatic logic [6:0] seg_of(win_e w);
    case (w)
      WIN_ONE: return SEG_ONE;
      WIN_TWO: return SEG_TWO;
      default: return SEG_BLANK;
    endcase
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic sync_no
);
  logic [STAGES-1:0] chain_q;

  // Reset to the released level (high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], raw_ni};
  end

  assign sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/press_detect.sv
module press_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_ni,
  output logic pulse_o
);
  typedef enum logic {ST_UP, ST_DOWN} pd_st_e;
  pd_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        st_q <= ST_UP;
    else if (!level_ni) st_q <= ST_DOWN;
    else                st_q <= ST_UP;
  end

  assign pulse_o = (st_q == ST_UP) && !level_ni;

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/field_cell.sv
module field_cell #(
  parameter bit INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic step_r_i,
  input  logic step_l_i,
  input  logic left_lit_i,
  input  logic right_lit_i,
  output logic lit_o
);
  logic lit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lit_q <= INIT;
    else if (freeze_i)              lit_q <= lit_q;
    else if (step_r_i && !step_l_i) lit_q <= left_lit_i;
    else if (step_l_i && !step_r_i) lit_q <= right_lit_i;
  end

  assign lit_o = lit_q;

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(lit_q));
endmodule

// File: rtl/win_unit.sv
module win_unit
  import rg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_r_i,
  input  logic       step_l_i,
  input  logic       right_end_i,
  input  logic       left_end_i,
  output logic       won_o,
  output logic [6:0] seg_o
);
  win_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= WIN_NONE;
    else if (st_q == WIN_NONE) begin
      if (step_r_i && !step_l_i && right_end_i)      st_q <= WIN_ONE;
      else if (step_l_i && !step_r_i && left_end_i)  st_q <= WIN_TWO;
    end
  end

  assign won_o = (st_q != WIN_NONE);
  assign seg_o = seg_of(st_q);

  assert_win_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won_o |=> $stable(seg_o));
  assert_no_tie_win_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!won_o && step_r_i && step_l_i) |=> !won_o);
endmodule

// File: rtl/rope_game_top.sv
module rope_game_top #(
  parameter int N_CELLS     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               btn_one_ni,
  input  logic               btn_two_ni,
  output logic [N_CELLS-1:0] lights_o,
  output logic [6:0]         seg_o
);
  localparam int CENTER = N_CELLS / 2;

  logic one_sync_n, two_sync_n;
  logic step_r, step_l;
  logic won;
  logic [N_CELLS+1:0] padded;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync_one (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_ni(btn_one_ni), .sync_no(one_sync_n));
  btn_sync #(.STAGES(SYNC_STAGES)) u_sync_two (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_ni(btn_two_ni), .sync_no(two_sync_n));

  press_detect u_pd_one (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_ni(one_sync_n), .pulse_o(step_r));
  press_detect u_pd_two (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_ni(two_sync_n), .pulse_o(step_l));

  // Dark cells beyond both ends
  assign padded = {1'b0, lights_o, 1'b0};

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    field_cell #(.INIT(i == CENTER)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .freeze_i   (won),
      .step_r_i   (step_r),
      .step_l_i   (step_l),
      .left_lit_i (padded[i+2]),
      .right_lit_i(padded[i]),
      .lit_o      (lights_o[i])
    );
  end

  win_unit u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_r_i   (step_r),
    .step_l_i   (step_l),
    .right_end_i(lights_o[0]),
    .left_end_i (lights_o[N_CELLS-1]),
    .won_o      (won),
    .seg_o      (seg_o)
  );

  assert_one_lit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !won |-> ($countones(lights_o) == 1));
  assert_tie_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_r && step_l) |=> $stable(lights_o));
  assert_dark_after_win_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    won |-> (lights_o == '0));
endmodule

// File: tb/sim_rope_game_top.sv
module sim_rope_game_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b1_n = 1'b1, b2_n = 1'b1;
  logic [8:0] lights;
  logic [6:0] seg;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rope_game_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .btn_one_ni(b1_n), .btn_two_ni(b2_n),
    .lights_o(lights), .seg_o(seg));

  // Behavioural reference model
  logic s1a, s1b, s2a, s2b, p1prev, p2prev;
  int   pos, winner;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1a = 1; s1b = 1; s2a = 1; s2b = 1; p1prev = 0; p2prev = 0;
      pos = 4; winner = 0;
    end else begin
      bit m1, m2;
      m1 = !s1b && !p1prev;
      m2 = !s2b && !p2prev;
      if (winner == 0 && m1 && !m2) begin
        if (pos == 0) begin winner = 1; pos = -1; end else pos = pos - 1;
      end else if (winner == 0 && m2 && !m1) begin
        if (pos == 8) begin winner = 2; pos = -1; end else pos = pos + 1;
      end
      p1prev = !s1b; p2prev = !s2b;
      s1b = s1a; s1a = b1_n;
      s2b = s2a; s2a = b2_n;
    end
  end

  function automatic logic [8:0] exp_lights();
    return (pos >= 0) ? (9'b1 << pos) : 9'b0;
  endfunction
  function automatic logic [6:0] exp_seg();
    return (winner == 1) ? 7'b1111001 : (winner == 2) ? 7'b0100100 : 7'b1111111;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 lights vs model", {7'b0, lights}, {7'b0, exp_lights()});
    chk("R6 digit vs model", {9'b0, seg}, {9'b0, exp_seg()});
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic press(bit one, bit two, int hold);
    @(negedge clk);
    if (one) b1_n = 0;
    if (two) b2_n = 0;
    cycles(hold);
    b1_n = 1; b2_n = 1;
    cycles(4);
  endtask
  task automatic do_reset();
    rst_n = 0; b1_n = 1; b2_n = 1;
    cycles(2);
    chk("R1 reset lights", {7'b0, lights}, 16'h0010);
    chk("R1 reset digit", {9'b0, seg}, 16'h007F);
    rst_n = 1;
    cycles(2);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 after release lights", {7'b0, lights}, 16'h0010);
    // R3 latency: raw low before edge k, lights change after edge k+2
    @(negedge clk); b1_n = 0;
    @(negedge clk); chk("R3 after 1st edge", {7'b0, lights}, 16'h0010);
    @(negedge clk); chk("R3 after 2nd edge", {7'b0, lights}, 16'h0010);
    @(negedge clk); chk("R3 after 3rd edge", {7'b0, lights}, 16'h0008);
    cycles(2); b1_n = 1; cycles(4);
    chk("R2 one step right", {7'b0, lights}, 16'h0008);
    press(0, 1, 30);
    chk("R4 long hold one step", {7'b0, lights}, 16'h0010);
    press(0, 1, 1);
    chk("R2 one step left", {7'b0, lights}, 16'h0020);
    press(1, 1, 3);
    chk("R5 tie holds mid", {7'b0, lights}, 16'h0020);
    for (int i = 0; i < 5; i++) press(1, 0, 2);
    chk("R2 at right end", {7'b0, lights}, 16'h0001);
    chk("R9 still playing", {9'b0, seg}, 16'h007F);
    press(1, 0, 2);
    chk("R6 p1 wins digit", {9'b0, seg}, 16'h0079);
    chk("R6 p1 wins dark", {7'b0, lights}, 16'h0000);
    press(0, 1, 2);
    press(1, 0, 2);
    chk("R8 ignored digit", {9'b0, seg}, 16'h0079);
    chk("R8 ignored lights", {7'b0, lights}, 16'h0000);
    do_reset();
    for (int i = 0; i < 4; i++) press(0, 1, 5);
    chk("R2 at left end", {7'b0, lights}, 16'h0100);
    press(1, 1, 2);
    chk("R5 tie at end no win", {9'b0, seg}, 16'h007F);
    chk("R5 tie at end lights", {7'b0, lights}, 16'h0100);
    press(0, 1, 2);
    chk("R7 p2 wins digit", {9'b0, seg}, 16'h0024);
    chk("R7 p2 wins dark", {7'b0, lights}, 16'h0000);
    press(0, 1, 2);
    chk("R8 ignored after p2", {9'b0, seg}, 16'h0024);
    do_reset();
    chk("R1 reset after win", {9'b0, seg}, 16'h007F);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule